// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block watches the write strobes a host issues to a parallel NOR flash device and works out which command is being given. Commands use the classic protocol: two unlock writes at fixed word addresses, then a command byte. The decoder reports the current command mode and raises one-cycle request pulses to the program engine and the erase engine. Those engines, the storage array, the status bits and the timers sit outside the block. Each engine answers with a completion pulse. The erase timer also sends a pulse when the window for queuing more sectors closes.

The byte address of each write is first scaled down to a word address by the bus width, which is set by a parameter (1, 2 or 4 bytes). Only the low 11 bits of that word address are compared with the two unlock addresses. The unlock addresses are taken from input ports while reset is held. An unlock-bypass mode lets a host issue repeated program commands without the unlock pair. A query mode returns to whichever mode it was entered from. The block also keeps track of which sectors a pending erase covers, so that it can suspend and resume that erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is held, and after it, `mode` is 0 (read array), `bypass` is 0 and no request is high. The unlock addresses are sampled while reset is held. Mode codes: 0 read array, 1 autoselect, 2 program, 3 erase setup, 4 chip erase, 5 sector erase, 6 query.
- R2: An unlock pair is data 0xAA at word address A followed by data 0x55 at word address B. The word address is the byte address divided by the bus width, and bits above bit 10 are ignored. Any mismatch returns the block to mode 0 and clears `bypass`.
- R3: The command write that follows an unlock pair must be at word address A, unless bypass is active. Data 0x90 gives autoselect, 0xA0 program, 0x80 erase setup, and 0x20 sets `bypass` while leaving the mode at 0. Any other data, or a wrong address, returns the block to mode 0.
- R4: In program mode, the next write raises `progReq` for one cycle and presents its address and data on `reqAddr` and `reqData`; a data byte of 0xF0 is programmed like any other. The mode stays 2 until `progDone`, and writes made in the meantime are ignored.
- R5: After 0x80, a second unlock pair followed by 0x10 at word address A raises `chipEraseReq` and sets mode 4. Data 0x30 at any address instead raises `sectorEraseReq` and sets mode 5.
- R6: Data 0x98 at word address 0x55 enters mode 6, either from read mode or from autoselect. A 0xF0 write in query mode returns to the mode it was entered from. Any other write in query mode returns the block to mode 0.
- R7: Data 0xF0 returns the block to mode 0 and clears `bypass`, except in three cases: while a program is pending, during a chip erase, and during a sector erase after its window has closed. In those cases it is ignored.
- R8: After 0x20, a 0xA0 written at any address starts a program without an unlock pair. Once `progDone` arrives, the block is back at the command write with `bypass` still 1. Data 0x00 in bypass autoselect clears `bypass` and returns the block to mode 0.
- R9: While the sector window is open, each 0x30 write raises another `sectorEraseReq`, and any write other than 0x30 or 0xB0 returns the block to mode 0. After `eraseWindowEnd`, writes are ignored until `eraseDone` returns the block to mode 0.
- R10: Data 0xB0 during a sector erase raises `suspendReq` and sets mode 0. A later 0x30 in read mode raises `resumeReq` and sets mode 5. When no erase is suspended, 0x30 in read mode just leaves the block in mode 0, and 0xB0 in read mode has no effect.
- R11: While an erase is suspended, a program write to a sector that is being erased raises no request. The block then goes to mode 0, or to the command write if bypass is active. A program to any other sector proceeds. An erase command issued during the suspension returns the block to mode 0 with no request.
- R12: Data 0x10 at an address other than A, in the last cycle of an erase command, raises no request and returns the block to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| unlockAddrA | input | 11 | First unlock word address, sampled during reset |
| unlockAddrB | input | 11 | Second unlock word address, sampled during reset |
| wrEn | input | 1 | Write strobe, one cycle per bus write |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 8 | Data byte of the write |
| progDone | input | 1 | Program engine finished |
| eraseWindowEnd | input | 1 | Window for adding sectors has closed |
| eraseDone | input | 1 | Erase engine finished |
| mode | output | 3 | Current command mode (codes in R1) |
| bypass | output | 1 | Unlock bypass active |
| progReq | output | 1 | Program request pulse |
| chipEraseReq | output | 1 | Chip erase request pulse |
| sectorEraseReq | output | 1 | Sector erase request pulse |
| suspendReq | output | 1 | Erase suspend request pulse |
| resumeReq | output | 1 | Erase resume request pulse |
| reqAddr | output | ADDR_W | Byte address captured with the last request |
| reqData | output | 8 | Data captured with the last request |

## Verification
All outputs come from registers. Each write therefore shows its effect on `mode`, `bypass`, the request pulses and the captured address and data from the first clock edge that samples the strobe, and a request pulse falls again at the next edge. Completion and window pulses act on that same first edge. The bench changes inputs on the falling edge and reads outputs one nanosecond after the following rising edge. This means every check looks at exactly the cycle in which the result is due, and a pulse that lasts one cycle too long is caught by the request check on the following write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    M_READ         = 3'd0,
    M_AUTOSEL      = 3'd1,
    M_PROGRAM      = 3'd2,
    M_ERASE_SETUP  = 3'd3,
    M_CHIP_ERASE   = 3'd4,
    M_SECTOR_ERASE = 3'd5,
    M_QUERY        = 3'd6
  } mode_e;

  typedef enum logic [3:0] {
    S_READ, S_UNLK1, S_CMD, S_AUTO, S_PROG_DATA, S_PROG_BUSY,
    S_ERS_UNLK0, S_ERS_UNLK1, S_ERS_CMD, S_CHIP_BUSY,
    S_SECT_WIN, S_SECT_BUSY, S_QUERY, S_QRY_AUTO
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic markSector;
    logic clearSectors;
    logic suspend;
    logic resume;
    logic capture;
  } dp_stb_t;

  localparam logic [7:0] D_UNLK1  = 8'hAA;
  localparam logic [7:0] D_UNLK2  = 8'h55;
  localparam logic [7:0] D_BYPASS = 8'h20;
  localparam logic [7:0] D_ERASE  = 8'h80;
  localparam logic [7:0] D_AUTO   = 8'h90;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_SECT   = 8'h30;
  localparam logic [7:0] D_SUSP   = 8'hB0;
  localparam logic [7:0] D_QUERY  = 8'h98;
  localparam logic [7:0] D_RESET  = 8'hF0;
  localparam logic [7:0] D_BYEXIT = 8'h00;

endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BUS_BYTES   = 2,
  parameter int CMP_W       = 11,
  parameter int SECTOR_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [CMP_W-1:0]  unlockAddrA,
  input  logic [CMP_W-1:0]  unlockAddrB,
  input  dp_stb_t           stb,
  output logic              hitA,
  output logic              hitB,
  output logic              hitQuery,
  output logic              suspended,
  output logic              sectorErasing,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData
);

  localparam int SHIFT       = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;
  localparam int NUM_SECTORS = 1 << SECTOR_BITS;
  localparam logic [CMP_W-1:0] QUERY_WORD = CMP_W'(8'h55);

  logic [CMP_W-1:0]       cmpAddr;
  logic [CMP_W-1:0]       latchA, latchB;
  logic [SECTOR_BITS-1:0] sectorIdx;
  logic [NUM_SECTORS-1:0] eraseMap;

  // word address scaled by bus width, low bits only
  generate
    if (SHIFT == 0) begin : g_byteBus
      assign cmpAddr = wrAddr[CMP_W-1:0];
    end else begin : g_wideBus
      assign cmpAddr = wrAddr[SHIFT +: CMP_W];
    end
  endgenerate

  assign sectorIdx = wrAddr[ADDR_W-1 -: SECTOR_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchA <= unlockAddrA;
      latchB <= unlockAddrB;
    end
  end

  assign hitA     = (cmpAddr == latchA);
  assign hitB     = (cmpAddr == latchB);
  assign hitQuery = (cmpAddr == QUERY_WORD);

  generate
    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_map
      always_ff @(posedge clk) begin
        if (!rstN)                                              eraseMap[s] <= 1'b0;
        else if (stb.markSector && sectorIdx == SECTOR_BITS'(s)) eraseMap[s] <= 1'b1;
        else if (stb.clearSectors)                              eraseMap[s] <= 1'b0;
      end
    end
  endgenerate

  assign sectorErasing = eraseMap[sectorIdx];

  always_ff @(posedge clk) begin
    if (!rstN)            suspended <= 1'b0;
    else if (stb.suspend) suspended <= 1'b1;
    else if (stb.resume)  suspended <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr <= '0;
      reqData <= '0;
    end else if (stb.capture) begin
      reqAddr <= wrAddr;
      reqData <= wrData;
    end
  end

  // R10
  suspend_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.suspend |=> suspended);
  // R10
  resume_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.resume && !stb.suspend) |=> !suspended);
  // R9
  mark_sector_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.markSector |=> eraseMap[$past(sectorIdx)]);

endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       hitA,
  input  logic       hitB,
  input  logic       hitQuery,
  input  logic       suspended,
  input  logic       sectorErasing,
  input  logic       progDone,
  input  logic       eraseDone,
  input  logic       windowEnd,
  output mode_e      mode,
  output logic       bypass,
  output logic       progReq,
  output logic       chipEraseReq,
  output logic       sectorEraseReq,
  output logic       suspendReq,
  output logic       resumeReq,
  output dp_stb_t    stb
);

  state_e state, nState;
  logic   nBypass, nProg, nChip, nSect, nSusp, nRes;
  logic   locked;

  assign locked = (state == S_PROG_DATA) || (state == S_PROG_BUSY) ||
                  (state == S_CHIP_BUSY) || (state == S_SECT_WIN)  ||
                  (state == S_SECT_BUSY);

  always_comb begin
    nState  = state;
    nBypass = bypass;
    nProg   = 1'b0;
    nChip   = 1'b0;
    nSect   = 1'b0;
    nSusp   = 1'b0;
    nRes    = 1'b0;
    stb     = '0;
    stb.clearSectors = eraseDone && !suspended;
    if (state == S_PROG_BUSY && progDone) begin
      nState = bypass ? S_CMD : S_READ;
    end else if ((state == S_CHIP_BUSY || state == S_SECT_BUSY) && eraseDone) begin
      nState = bypass ? S_CMD : S_READ;
    end else if (wrEn) begin
      if (wrData == D_RESET && !locked) begin
        if (state == S_QRY_AUTO) begin
          nState = S_AUTO;
        end else begin
          nState  = S_READ;
          nBypass = 1'b0;
        end
      end else begin
        nState  = S_READ;     // default: any rejected write resets
        nBypass = 1'b0;
        case (state)
          S_READ: begin
            if (hitQuery && wrData == D_QUERY) begin
              nState = S_QUERY;  nBypass = bypass;
            end else if (wrData == D_SECT) begin
              if (suspended) begin
                nState = S_SECT_BUSY; nBypass = bypass;
                nRes = 1'b1; stb.resume = 1'b1;
              end
            end else if (wrData == D_SUSP) begin
              nState = S_READ; nBypass = bypass;
            end else if (hitA && wrData == D_UNLK1) begin
              nState = S_UNLK1; nBypass = bypass;
            end
          end
          S_UNLK1:
            if (hitB && wrData == D_UNLK2) begin
              nState = S_CMD; nBypass = bypass;
            end
          S_CMD:
            if (bypass || hitA) begin
              nBypass = bypass;
              case (wrData)
                D_BYPASS: begin nState = S_CMD; nBypass = 1'b1; end
                D_ERASE:  nState = S_ERS_UNLK0;
                D_AUTO:   nState = S_AUTO;
                D_PROG:   nState = S_PROG_DATA;
                default:  begin nState = S_READ; nBypass = 1'b0; end
              endcase
            end
          S_AUTO:
            if (!(bypass && wrData == D_BYEXIT) && hitQuery && wrData == D_QUERY) begin
              nState = S_QRY_AUTO; nBypass = bypass;
            end
          S_PROG_DATA: begin
            nBypass = bypass;
            if (suspended && sectorErasing) begin
              nState = bypass ? S_CMD : S_READ;
            end else begin
              nState = S_PROG_BUSY;
              nProg = 1'b1; stb.capture = 1'b1;
            end
          end
          S_PROG_BUSY: begin
            nState = state; nBypass = bypass;
          end
          S_ERS_UNLK0:
            if (hitA && wrData == D_UNLK1) begin
              nState = S_ERS_UNLK1; nBypass = bypass;
            end
          S_ERS_UNLK1:
            if (hitB && wrData == D_UNLK2) begin
              nState = S_ERS_CMD; nBypass = bypass;
            end
          S_ERS_CMD:
            if (!suspended) begin
              if (wrData == D_CHIP && hitA) begin
                nState = S_CHIP_BUSY; nBypass = bypass;
                nChip = 1'b1; stb.capture = 1'b1;
              end else if (wrData == D_SECT) begin
                nState = S_SECT_WIN; nBypass = bypass;
                nSect = 1'b1; stb.capture = 1'b1; stb.markSector = 1'b1;
              end
            end
          S_CHIP_BUSY: begin
            nState = state; nBypass = bypass;
          end
          S_SECT_WIN, S_SECT_BUSY: begin
            if (wrData == D_SUSP) begin
              nState = S_READ; nBypass = bypass;
              nSusp = 1'b1; stb.suspend = 1'b1;
            end else if (state == S_SECT_BUSY) begin
              nState = state; nBypass = bypass;
            end else if (wrData == D_SECT) begin
              nState = S_SECT_WIN; nBypass = bypass;
              nSect = 1'b1; stb.capture = 1'b1; stb.markSector = 1'b1;
            end
          end
          default: ;  // query modes: any other write resets
        endcase
      end
    end else if (state == S_SECT_WIN && windowEnd) begin
      nState = S_SECT_BUSY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= S_READ;
      bypass         <= 1'b0;
      progReq        <= 1'b0;
      chipEraseReq   <= 1'b0;
      sectorEraseReq <= 1'b0;
      suspendReq     <= 1'b0;
      resumeReq      <= 1'b0;
    end else begin
      state          <= nState;
      bypass         <= nBypass;
      progReq        <= nProg;
      chipEraseReq   <= nChip;
      sectorEraseReq <= nSect;
      suspendReq     <= nSusp;
      resumeReq      <= nRes;
    end
  end

  always_comb begin
    case (state)
      S_AUTO:                              mode = M_AUTOSEL;
      S_PROG_DATA, S_PROG_BUSY:            mode = M_PROGRAM;
      S_ERS_UNLK0, S_ERS_UNLK1, S_ERS_CMD: mode = M_ERASE_SETUP;
      S_CHIP_BUSY:                         mode = M_CHIP_ERASE;
      S_SECT_WIN, S_SECT_BUSY:             mode = M_SECTOR_ERASE;
      S_QUERY, S_QRY_AUTO:                 mode = M_QUERY;
      default:                             mode = M_READ;
    endcase
  end

  // R4
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, chipEraseReq, sectorEraseReq, suspendReq, resumeReq}));
  // R4
  prog_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> mode == M_PROGRAM);
  // R5
  chip_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipEraseReq |-> mode == M_CHIP_ERASE);
  // R9
  sect_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    sectorEraseReq |-> mode == M_SECTOR_ERASE);
  // R10
  susp_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspendReq |-> mode == M_READ);
  // R10
  resume_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> mode == M_SECTOR_ERASE);
  // R8
  bypass_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bypass) |-> mode == M_READ);
  // R7
  chip_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_CHIP_ERASE && !eraseDone) |=> mode == M_CHIP_ERASE);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BUS_BYTES   = 2,
  parameter int CMP_W       = 11,
  parameter int SECTOR_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMP_W-1:0]  unlockAddrA,
  input  logic [CMP_W-1:0]  unlockAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              progDone,
  input  logic              eraseWindowEnd,
  input  logic              eraseDone,
  output logic [2:0]        mode,
  output logic              bypass,
  output logic              progReq,
  output logic              chipEraseReq,
  output logic              sectorEraseReq,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData
);

  dp_stb_t stb;
  mode_e   modeInt;
  logic    hitA, hitB, hitQuery, suspended, sectorErasing;

  fcd_datapath #(
    .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .CMP_W(CMP_W), .SECTOR_BITS(SECTOR_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .unlockAddrA(unlockAddrA), .unlockAddrB(unlockAddrB), .stb(stb),
    .hitA(hitA), .hitB(hitB), .hitQuery(hitQuery), .suspended(suspended),
    .sectorErasing(sectorErasing), .reqAddr(reqAddr), .reqData(reqData)
  );

  fcd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .hitA(hitA), .hitB(hitB), .hitQuery(hitQuery), .suspended(suspended),
    .sectorErasing(sectorErasing), .progDone(progDone), .eraseDone(eraseDone),
    .windowEnd(eraseWindowEnd), .mode(modeInt), .bypass(bypass),
    .progReq(progReq), .chipEraseReq(chipEraseReq), .sectorEraseReq(sectorEraseReq),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .stb(stb)
  );

  assign mode = modeInt;

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  localparam int ADDR_W = 20;
  localparam logic [10:0] UA = 11'h555;
  localparam logic [10:0] UB = 11'h2AA;
  // mode codes
  localparam int MR = 0, MA = 1, MP = 2, ME = 3, MC = 4, MS = 5, MQ = 6;
  // request vector {prog, chip, sect, susp, resume}
  localparam logic [4:0] RNONE = 5'b00000, RPROG = 5'b10000, RCHIP = 5'b01000,
                         RSECT = 5'b00100, RSUSP = 5'b00010, RRES  = 5'b00001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic progDone = 1'b0, eraseWindowEnd = 1'b0, eraseDone = 1'b0;
  logic [2:0] mode;
  logic bypass, progReq, chipEraseReq, sectorEraseReq, suspendReq, resumeReq;
  logic [ADDR_W-1:0] reqAddr;
  logic [7:0] reqData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rstN(rstN), .unlockAddrA(UA), .unlockAddrB(UB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .progDone(progDone),
    .eraseWindowEnd(eraseWindowEnd), .eraseDone(eraseDone), .mode(mode),
    .bypass(bypass), .progReq(progReq), .chipEraseReq(chipEraseReq),
    .sectorEraseReq(sectorEraseReq), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .reqAddr(reqAddr), .reqData(reqData)
  );

  function automatic logic [4:0] reqVec();
    return {progReq, chipEraseReq, sectorEraseReq, suspendReq, resumeReq};
  endfunction

  // expected mode after a single write from an idle read state
  function automatic int expFirst(input logic [18:0] word, input logic [7:0] d);
    if (word[10:0] == 11'h055 && d == 8'h98) return MQ;
    return MR;
  endfunction

  function automatic logic [ADDR_W-1:0] secByte(input int s, input int off);
    return ADDR_W'((s << 16) | (off & 16'hFFFE));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input int expMode, input logic expBy,
                          input logic [4:0] expReq);
    chk({tag, " mode"}, int'(mode), expMode);
    chk({tag, " bypass"}, int'(bypass), int'(expBy));
    chk({tag, " req"}, int'(reqVec()), int'(expReq));
  endtask

  task automatic wrb(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic wrw(input logic [18:0] w, input logic [7:0] d);
    wrb({w, 1'b0}, d);
  endtask

  task automatic unlock();
    wrw(19'(UA), 8'hAA);
    wrw(19'(UB), 8'h55);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) progDone = 1'b1;
    else if (which == 1) eraseWindowEnd = 1'b1;
    else eraseDone = 1'b1;
    @(posedge clk); #1;
    progDone = 1'b0; eraseWindowEnd = 1'b0; eraseDone = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1; chkState("R1 in reset", MR, 1'b0, RNONE);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chkState("R1 after reset", MR, 1'b0, RNONE);

    // R3 autoselect, R6 query both ways
    unlock(); wrw(19'(UA), 8'h90);      chkState("R3 autoselect", MA, 1'b0, RNONE);
    wrw(19'h055, 8'h98);                chkState("R6 query from autoselect", MQ, 1'b0, RNONE);
    wrw(19'h100, 8'hF0);                chkState("R6 reset back to autoselect", MA, 1'b0, RNONE);
    wrw(19'h100, 8'h12);                chkState("R3 stray write in autoselect", MR, 1'b0, RNONE);
    wrw(19'h055, 8'h98);                chkState("R6 query from read", MQ, 1'b0, RNONE);
    wrw(19'h055, 8'hF0);                chkState("R6 reset back to read", MR, 1'b0, RNONE);
    wrw(19'h055, 8'h98); wrw(19'h000, 8'h44);
    chkState("R6 other write in query", MR, 1'b0, RNONE);

    // R2 address scaling and masking
    wrb(20'(UA), 8'hAA); wrw(19'(UB), 8'h55); wrw(19'(UA), 8'h90);
    chkState("R2 unscaled byte address rejected", MR, 1'b0, RNONE);
    wrw(19'(UA) | 19'h1800, 8'hAA); wrw(19'(UB) | 19'h4000, 8'h55); wrw(19'(UA), 8'h90);
    chkState("R2 upper address bits ignored", MA, 1'b0, RNONE);
    wrw(19'h0, 8'hF0);                  chkState("R7 reset from autoselect", MR, 1'b0, RNONE);
    wrw(19'(UA), 8'hAA); wrw(19'h123, 8'h55); wrw(19'(UA), 8'h90);
    chkState("R2 second unlock at wrong address", MR, 1'b0, RNONE);

    // R3 wrong command address / data
    unlock(); wrw(19'h123, 8'h90);      chkState("R3 command at wrong address", MR, 1'b0, RNONE);
    unlock(); wrw(19'(UA), 8'h55);      chkState("R3 unknown command", MR, 1'b0, RNONE);

    // R4 program, F0 as data, ignored writes
    unlock(); wrw(19'(UA), 8'hA0);      chkState("R4 program setup", MP, 1'b0, RNONE);
    wrb(20'h3_1234, 8'hF0);             chkState("R4 program data", MP, 1'b0, RPROG);
    chk("R4 reqAddr", int'(reqAddr), 32'h3_1234);
    chk("R4 reqData", int'(reqData), 8'hF0);
    wrw(19'h0, 8'hF0);                  chkState("R7 F0 ignored while programming", MP, 1'b0, RNONE);
    pulse(0);                           chkState("R4 program done", MR, 1'b0, RNONE);

    // R5 chip erase
    unlock(); wrw(19'(UA), 8'h80);      chkState("R5 erase setup", ME, 1'b0, RNONE);
    wrw(19'h0, 8'hF0);                  chkState("R7 reset from erase setup", MR, 1'b0, RNONE);
    unlock(); wrw(19'(UA), 8'h80); unlock(); wrw(19'(UA), 8'h10);
    chkState("R5 chip erase", MC, 1'b0, RCHIP);
    wrw(19'h0, 8'hF0);                  chkState("R7 F0 ignored in chip erase", MC, 1'b0, RNONE);
    pulse(2);                           chkState("R5 chip erase done", MR, 1'b0, RNONE);
    unlock(); wrw(19'(UA), 8'h80); unlock(); wrw(19'h321, 8'h10);
    chkState("R12 chip erase at wrong address", MR, 1'b0, RNONE);

    // R9 sector window
    unlock(); wrw(19'(UA), 8'h80); unlock(); wrb(secByte(3, 16'h40), 8'h30);
    chkState("R5 sector erase", MS, 1'b0, RSECT);
    chk("R5 sector reqAddr", int'(reqAddr), int'(secByte(3, 16'h40)));
    wrb(secByte(5, 0), 8'h30);          chkState("R9 add sector", MS, 1'b0, RSECT);
    pulse(1);                           chkState("R9 window closed", MS, 1'b0, RNONE);
    wrb(secByte(7, 0), 8'h30);          chkState("R9 write ignored after window", MS, 1'b0, RNONE);
    wrw(19'h0, 8'hF0);                  chkState("R7 F0 ignored in sector erase", MS, 1'b0, RNONE);
    pulse(2);                           chkState("R9 sector erase done", MR, 1'b0, RNONE);
    unlock(); wrw(19'(UA), 8'h80); unlock(); wrb(secByte(1, 0), 8'h30);
    wrw(19'h0, 8'h55);                  chkState("R9 stray write in window", MR, 1'b0, RNONE);
    pulse(2);

    // R10 / R11 suspend, discard, resume
    unlock(); wrw(19'(UA), 8'h80); unlock(); wrb(secByte(2, 0), 8'h30);
    wrw(19'h0, 8'hB0);                  chkState("R10 suspend in window", MR, 1'b0, RSUSP);
    unlock(); wrw(19'(UA), 8'hA0); wrb(secByte(2, 16'h10), 8'h5A);
    chkState("R11 program to erasing sector discarded", MR, 1'b0, RNONE);
    unlock(); wrw(19'(UA), 8'hA0); wrb(secByte(6, 16'h10), 8'h5A);
    chkState("R11 program to other sector", MP, 1'b0, RPROG);
    pulse(0);
    unlock(); wrw(19'(UA), 8'h80); unlock(); wrb(secByte(4, 0), 8'h30);
    chkState("R11 erase while suspended", MR, 1'b0, RNONE);
    wrw(19'h0, 8'h30);                  chkState("R10 resume", MS, 1'b0, RRES);
    wrw(19'h0, 8'hB0);                  chkState("R10 suspend when busy", MR, 1'b0, RSUSP);
    wrw(19'h0, 8'h30);                  chkState("R10 resume again", MS, 1'b0, RRES);
    pulse(2);                           chkState("R10 erase done", MR, 1'b0, RNONE);
    wrw(19'h0, 8'h30);                  chkState("R10 resume without suspend", MR, 1'b0, RNONE);
    wrw(19'h0, 8'hB0);                  chkState("R10 suspend in read ignored", MR, 1'b0, RNONE);
    unlock(); wrw(19'(UA), 8'hA0); wrb(secByte(2, 16'h10), 8'h11);
    chkState("R11 sector released after erase", MP, 1'b0, RPROG);
    pulse(0);

    // R8 bypass
    unlock(); wrw(19'(UA), 8'h20);      chkState("R8 enter bypass", MR, 1'b1, RNONE);
    wrw(19'h777, 8'hA0);                chkState("R8 bypass program setup", MP, 1'b1, RNONE);
    wrb(20'h0_0A0A, 8'h3C);             chkState("R8 bypass program", MP, 1'b1, RPROG);
    pulse(0);                           chkState("R8 bypass program done", MR, 1'b1, RNONE);
    wrw(19'h0, 8'hA0); wrb(20'h0_0B0B, 8'hC3);
    chkState("R8 second program no unlock", MP, 1'b1, RPROG);
    chk("R8 reqData", int'(reqData), 8'hC3);
    pulse(0);
    wrw(19'h012, 8'h90);                chkState("R8 bypass autoselect", MA, 1'b1, RNONE);
    wrw(19'h0, 8'h00);                  chkState("R8 leave bypass", MR, 1'b0, RNONE);
    unlock(); wrw(19'(UA), 8'h20); wrw(19'h0, 8'hF0);
    chkState("R7 F0 clears bypass", MR, 1'b0, RNONE);

    // R2 random single writes from read, then clean up
    for (int i = 0; i < 40; i++) begin
      logic [18:0] w;
      logic [7:0] d;
      w = 19'($urandom());
      d = 8'($urandom());
      if (i % 4 == 0) w[10:0] = 11'h055;
      if (i % 5 == 0) d = 8'h98;
      wrw(w, d);
      chkState("R2 random first write", expFirst(w, d), 1'b0, RNONE);
      wrw(19'h0, 8'hF0);
    end

    // R4 random programs
    for (int i = 0; i < 30; i++) begin
      logic [ADDR_W-1:0] a;
      logic [7:0] d;
      a = ADDR_W'($urandom());
      d = 8'($urandom());
      unlock(); wrw(19'(UA), 8'hA0); wrb(a, d);
      chkState("R4 random program", MP, 1'b0, RPROG);
      chk("R4 random reqAddr", int'(reqAddr), int'(a));
      chk("R4 random reqData", int'(reqData), int'(d));
      pulse(0);
      chk("R4 random done mode", int'(mode), MR);
    end

    finishRun();
  end

endmodule